// File: doc/BRIEF.md
# Scan Pattern Sanity Monitor

This block watches a stream of scan test vectors one vector per clock cycle and flags vectors that break a fixed set of pin rules. A pattern has two phases. In the setup phase the JTAG pins program the device while the scan logic stays quiet. In the scan phase the scan chains are loaded, captured and unloaded. The `setupDone` input is low for every setup vector and high from the first scan-phase vector onward.

During setup the monitor counts toggles on TCK, TMS and TDI. It tracks the pulse shape of the three active-low resets and of scan enable, and it checks that the scan clocks, the scan inputs and the scan-out compare flags stay idle. In the scan phase it follows the capture windows, which are the stretches where scan enable is low after a load. It also watches for compares during the first load, and for real compares after the second capture pulse.

Each rule owns one sticky bit of `errFlags`, and the bit index is the error code. A one-cycle `patEnd` strobe latches a pass/fail verdict. A new pattern starts from reset.

Top module: `scanmon_top`

## Requirements
- R1: TCK, TMS and TDI toggles are counted only on setup vectors. A toggle is a change from the previous vector, and the reference level right after reset is 0. Each count saturates at 65535, and scan-phase vectors leave the counts unchanged.
- R2: On the first vector with `setupDone` high, bit 0 of `errFlags` is set if the TDI toggle count is zero or is not greater than the TMS toggle count.
- R3: On that same setup-end vector, bit 1 is set unless each of `trstN`, `sysRstN` and `auxRstN` went low exactly once and came back high exactly once during setup. Each of these pins is taken as high at reset.
- R4: On the setup-end vector, bit 2 is set unless scan enable rose exactly once and fell back exactly once during setup. Scan enable is taken as low at reset.
- R5: On a setup vector where any scan clock or scan input differs from the previous vector, or where any scan-out compare flag is set, bit 3 is set.
- R6: A capture window is a run of vectors with scan enable low, after scan enable has been high at least once in the scan phase. Bit 4 is set on the vector that closes a window (scan enable back high) if no scan clock rose inside the window.
- R7: Bit 5 is set if any scan clock is high on the first vector of a capture window or on the vector that closes it.
- R8: Bit 6 is set by any scan-out compare on a scan-phase vector before the first capture window opens.
- R9: On the `patEnd` vector, bit 7 is set unless a scan-out compare appeared in the scan phase on a vector after the one carrying the second capture pulse. A capture pulse is a vector inside a window on which any scan clock rises. A compare on the `patEnd` vector itself counts.
- R10: Error bits are sticky. A `clearErr` vector zeroes all bits and the verdict, and any error detected on that same vector is dropped.
- R11: A `patEnd` vector sets `verdictValid`. It also loads `verdictFail` with the OR of all error bits, including errors found on that vector.
- R12: Every flag and verdict shows up in the cycle after the clock edge that sampled the vector that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Vector clock, one vector per rising edge |
| rstN | input | 1 | Active-low reset, starts a new pattern |
| clearErr | input | 1 | Clears error bits and verdict |
| setupDone | input | 1 | Low on setup vectors, high in the scan phase |
| patEnd | input | 1 | Marks the last vector of the pattern |
| tck | input | 1 | JTAG clock pin value |
| tms | input | 1 | JTAG mode-select pin value |
| tdi | input | 1 | JTAG data-in pin value |
| trstN | input | 1 | JTAG reset pin value (active low) |
| sysRstN | input | 1 | System reset pin value (active low) |
| auxRstN | input | 1 | Extra reset pin value (active low) |
| scanEn | input | 1 | Scan enable pin value |
| scanClk | input | CLK_N | Scan clock pin values |
| scanIn | input | SIN_N | Scan input pin values |
| soCmp | input | SOUT_N | Compare flags on scan outputs |
| errFlags | output | 8 | Sticky error bits, index is the code |
| tckCount | output | CNT_W | Setup TCK toggle count |
| tmsCount | output | CNT_W | Setup TMS toggle count |
| tdiCount | output | CNT_W | Setup TDI toggle count |
| verdictValid | output | 1 | Verdict latched by patEnd |
| verdictFail | output | 1 | Pattern failed any rule |

## Verification
Every result is registered once, so each error bit, count and verdict is due one cycle after the rising edge that samples its vector. The setup rules of R2 to R4 appear after the first scan-phase vector. The capture rules appear after the closing or opening vector, and the no-compare verdict appears after `patEnd`. The bench drives each vector on the falling edge and samples 1 ns after the next rising edge. It compares `errFlags` on every vector of a clean reference pattern and of single-vector mutations of it, so a flag raised one vector early or late is caught.

// File: rtl/scanmon_pkg.sv
package scanmon_pkg;
  localparam int ERR_W = 8;
  localparam int E_TDI     = 0;
  localparam int E_RST     = 1;
  localparam int E_SE      = 2;
  localparam int E_QUIET   = 3;
  localparam int E_NOCAP   = 4;
  localparam int E_CAPLVL  = 5;
  localparam int E_LOADCMP = 6;
  localparam int E_NOCMP   = 7;

  typedef enum logic [1:0] {PH_SETUP, PH_LOAD0, PH_LOAD1, PH_SCAN} phase_e;

  typedef struct packed {
    logic inSetup;
    logic setupEnd;
    logic firstLoad;
    logic inCapture;
    logic capOpen;
    logic capClose;
    logic scanPhase;
    logic patEnd;
    logic clear;
  } strobe_t;
endpackage

// File: rtl/scanmon_pulse.sv
// Counts departures from and returns to an idle level while enabled.
module scanmon_pulse #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic en,
  input  logic pin,
  output logic shapeOk
);
  logic       prevQ;
  logic [1:0] leaveQ;
  logic [1:0] backQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevQ  <= IDLE;
      leaveQ <= 2'd0;
      backQ  <= 2'd0;
    end else if (en) begin
      prevQ <= pin;
      if (prevQ == IDLE && pin != IDLE && leaveQ != 2'd2) leaveQ <= leaveQ + 2'd1;
      if (prevQ != IDLE && pin == IDLE && backQ != 2'd2) backQ <= backQ + 2'd1;
    end
  end

  assign shapeOk = (leaveQ == 2'd1) && (backQ == 2'd1);
endmodule

// File: rtl/scanmon_ctrl.sv
// Phase tracking: setup, first load (before/after scan enable high), scan.
module scanmon_ctrl
  import scanmon_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    setupDone,
  input  logic    scanEn,
  input  logic    patEnd,
  input  logic    clearErr,
  output strobe_t stb
);
  phase_e phQ, phNext;
  logic   seQ;

  always_comb begin
    phNext = phQ;
    unique case (phQ)
      PH_SETUP: if (setupDone) phNext = PH_LOAD0;
      PH_LOAD0: if (scanEn)    phNext = PH_LOAD1;
      PH_LOAD1: if (!scanEn)   phNext = PH_SCAN;
      default:                 phNext = PH_SCAN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phQ <= PH_SETUP;
      seQ <= 1'b0;
    end else begin
      phQ <= phNext;
      seQ <= scanEn;
    end
  end

  always_comb begin
    stb.inSetup   = (phQ == PH_SETUP) && !setupDone;
    stb.setupEnd  = (phQ == PH_SETUP) && setupDone;
    stb.firstLoad = stb.setupEnd || (phQ == PH_LOAD0) || ((phQ == PH_LOAD1) && scanEn);
    stb.inCapture = ((phQ == PH_LOAD1) || (phQ == PH_SCAN)) && !scanEn;
    stb.capOpen   = !scanEn && ((phQ == PH_LOAD1) || ((phQ == PH_SCAN) && seQ));
    stb.capClose  = (phQ == PH_SCAN) && scanEn && !seQ;
    stb.scanPhase = (phQ == PH_SCAN);
    stb.patEnd    = patEnd;
    stb.clear     = clearErr;
  end
endmodule

// File: rtl/scanmon_dp.sv
// Counters, shape trackers, capture bookkeeping and sticky error register.
module scanmon_dp
  import scanmon_pkg::*;
#(
  parameter int CLK_N  = 4,
  parameter int SIN_N  = 4,
  parameter int SOUT_N = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              tck,
  input  logic              tms,
  input  logic              tdi,
  input  logic              trstN,
  input  logic              sysRstN,
  input  logic              auxRstN,
  input  logic              scanEn,
  input  logic [CLK_N-1:0]  scanClk,
  input  logic [SIN_N-1:0]  scanIn,
  input  logic [SOUT_N-1:0] soCmp,
  output logic [ERR_W-1:0]  errFlags,
  output logic [CNT_W-1:0]  tckCount,
  output logic [CNT_W-1:0]  tmsCount,
  output logic [CNT_W-1:0]  tdiCount,
  output logic              verdictValid,
  output logic              verdictFail
);
  localparam int          JTAG_N   = 3;
  localparam int          SHAPE_N  = 4;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [SHAPE_N-1:0] IDLE_LVL = 4'b0111;

  logic [JTAG_N-1:0]             jtagPin, jtagQ;
  logic [JTAG_N-1:0][CNT_W-1:0]  cntOut;
  logic [SHAPE_N-1:0]            shapePin, shapeOk;
  logic [CLK_N-1:0]              clkQ;
  logic [SIN_N-1:0]              sinQ;
  logic                          anyRise, anyCmp;
  logic                          winPulseQ, postCmpQ;
  logic [1:0]                    capCntQ;
  logic [ERR_W-1:0]              errQ, newErr;

  assign jtagPin  = {tdi, tms, tck};
  assign shapePin = {scanEn, auxRstN, sysRstN, trstN};
  assign anyRise  = |(scanClk & ~clkQ);
  assign anyCmp   = |soCmp;

  for (genvar g = 0; g < JTAG_N; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rstN) cnt <= '0;
      else if (stb.inSetup && (jtagPin[g] ^ jtagQ[g]) && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
    assign cntOut[g] = cnt;
  end

  for (genvar s = 0; s < SHAPE_N; s++) begin : g_shape
    scanmon_pulse #(.IDLE(IDLE_LVL[s])) u_pulse (
      .clk(clk), .rstN(rstN), .en(stb.inSetup), .pin(shapePin[s]), .shapeOk(shapeOk[s])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      jtagQ     <= '0;
      clkQ      <= '0;
      sinQ      <= '0;
      winPulseQ <= 1'b0;
      capCntQ   <= 2'd0;
      postCmpQ  <= 1'b0;
    end else begin
      jtagQ <= jtagPin;
      clkQ  <= scanClk;
      sinQ  <= scanIn;
      if (stb.capClose) winPulseQ <= 1'b0;
      else if (stb.inCapture && anyRise) winPulseQ <= 1'b1;
      if (stb.inCapture && anyRise && capCntQ != 2'd2) capCntQ <= capCntQ + 2'd1;
      if (stb.scanPhase && capCntQ == 2'd2 && anyCmp) postCmpQ <= 1'b1;
    end
  end

  always_comb begin
    newErr            = '0;
    newErr[E_TDI]     = stb.setupEnd && (cntOut[2] <= cntOut[1]);
    newErr[E_RST]     = stb.setupEnd && !(&shapeOk[2:0]);
    newErr[E_SE]      = stb.setupEnd && !shapeOk[3];
    newErr[E_QUIET]   = stb.inSetup && ((|(scanClk ^ clkQ)) || (|(scanIn ^ sinQ)) || anyCmp);
    newErr[E_NOCAP]   = stb.capClose && !winPulseQ;
    newErr[E_CAPLVL]  = (stb.capOpen || stb.capClose) && (|scanClk);
    newErr[E_LOADCMP] = stb.firstLoad && anyCmp;
    newErr[E_NOCMP]   = stb.patEnd &&
                        !(postCmpQ || (stb.scanPhase && capCntQ == 2'd2 && anyCmp));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errQ         <= '0;
      verdictValid <= 1'b0;
      verdictFail  <= 1'b0;
    end else if (stb.clear) begin
      errQ         <= '0;
      verdictValid <= 1'b0;
      verdictFail  <= 1'b0;
    end else begin
      errQ <= errQ | newErr;
      if (stb.patEnd) begin
        verdictValid <= 1'b1;
        verdictFail  <= |(errQ | newErr);
      end
    end
  end

  assign errFlags = errQ;
  assign tckCount = cntOut[0];
  assign tmsCount = cntOut[1];
  assign tdiCount = cntOut[2];
endmodule

// File: rtl/scanmon_top.sv
module scanmon_top
  import scanmon_pkg::*;
#(
  parameter int CLK_N  = 4,
  parameter int SIN_N  = 4,
  parameter int SOUT_N = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearErr,
  input  logic              setupDone,
  input  logic              patEnd,
  input  logic              tck,
  input  logic              tms,
  input  logic              tdi,
  input  logic              trstN,
  input  logic              sysRstN,
  input  logic              auxRstN,
  input  logic              scanEn,
  input  logic [CLK_N-1:0]  scanClk,
  input  logic [SIN_N-1:0]  scanIn,
  input  logic [SOUT_N-1:0] soCmp,
  output logic [7:0]        errFlags,
  output logic [CNT_W-1:0]  tckCount,
  output logic [CNT_W-1:0]  tmsCount,
  output logic [CNT_W-1:0]  tdiCount,
  output logic              verdictValid,
  output logic              verdictFail
);
  strobe_t stb;

  scanmon_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .setupDone(setupDone), .scanEn(scanEn),
    .patEnd(patEnd), .clearErr(clearErr), .stb(stb)
  );

  scanmon_dp #(.CLK_N(CLK_N), .SIN_N(SIN_N), .SOUT_N(SOUT_N), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .tck(tck), .tms(tms), .tdi(tdi), .trstN(trstN), .sysRstN(sysRstN), .auxRstN(auxRstN),
    .scanEn(scanEn), .scanClk(scanClk), .scanIn(scanIn), .soCmp(soCmp),
    .errFlags(errFlags), .tckCount(tckCount), .tmsCount(tmsCount), .tdiCount(tdiCount),
    .verdictValid(verdictValid), .verdictFail(verdictFail)
  );
endmodule

// File: rtl/scanmon_chk.sv
module scanmon_chk #(
  parameter int SOUT_N = 4,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              clearErr,
  input logic              setupDone,
  input logic              patEnd,
  input logic [SOUT_N-1:0] soCmp,
  input logic [7:0]        errFlags,
  input logic [CNT_W-1:0]  tckCount,
  input logic              verdictValid,
  input logic              verdictFail
);
  logic seenDone;
  always_ff @(posedge clk) begin
    if (!rstN) seenDone <= 1'b0;
    else if (setupDone) seenDone <= 1'b1;
  end

  // R10
  sticky_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clearErr |=> ((errFlags & $past(errFlags)) == $past(errFlags)));

  // R10
  clear_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearErr |=> (errFlags == 8'h00 && !verdictValid));

  // R11
  verdict_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (patEnd && !clearErr) |=> (verdictValid && (verdictFail == (|errFlags))));

  // R11
  fail_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    verdictFail |-> verdictValid);

  // R1
  count_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    seenDone |=> (tckCount == $past(tckCount)));

  // R5
  setup_cmp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!seenDone && !setupDone && (|soCmp) && !clearErr) |=> errFlags[3]);
endmodule

bind scanmon_top scanmon_chk #(.SOUT_N(SOUT_N), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .clearErr(clearErr), .setupDone(setupDone), .patEnd(patEnd),
  .soCmp(soCmp), .errFlags(errFlags), .tckCount(tckCount),
  .verdictValid(verdictValid), .verdictFail(verdictFail)
);

// File: tb/sim_scanmon_top.sv
`timescale 1ns/1ps
module sim_scanmon_top;
  logic clk = 1'b0;
  logic rstN, clearErr, setupDone, patEnd, tck, tms, tdi, trstN, sysRstN, auxRstN, scanEn;
  logic [3:0] scanClk, scanIn, soCmp;
  logic [7:0] errFlags;
  logic [15:0] tckCount, tmsCount, tdiCount;
  logic verdictValid, verdictFail;
  int checks = 0;
  int errors = 0;
  int wdog = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  scanmon_top u0 (
    .clk(clk), .rstN(rstN), .clearErr(clearErr), .setupDone(setupDone), .patEnd(patEnd),
    .tck(tck), .tms(tms), .tdi(tdi), .trstN(trstN), .sysRstN(sysRstN), .auxRstN(auxRstN),
    .scanEn(scanEn), .scanClk(scanClk), .scanIn(scanIn), .soCmp(soCmp),
    .errFlags(errFlags), .tckCount(tckCount), .tmsCount(tmsCount), .tdiCount(tdiCount),
    .verdictValid(verdictValid), .verdictFail(verdictFail)
  );

  // vector: [21] verdict due, [20] setupDone, [19] patEnd, [18] tck, [17] tms, [16] tdi,
  // [15] trstN, [14] sysRstN, [13] auxRstN, [12] scanEn, [11:8] clk, [7:4] sin, [3:0] cmp
  function automatic logic [21:0] mk(input logic sd, pe, k, m, d, r0, r1, r2, se,
                                     input logic [3:0] c, s, o, input logic v);
    return {v, sd, pe, k, m, d, r0, r1, r2, se, c, s, o};
  endfunction

  localparam int NROW = 18;
  localparam logic [21:0] TAB [NROW] = '{
    mk(0,0,0,0,0,0,0,0,0,4'h0,4'h0,4'h0,0),
    mk(0,0,1,0,1,1,1,1,0,4'h0,4'h0,4'h0,0),
    mk(0,0,0,1,0,1,1,1,0,4'h0,4'h0,4'h0,0),
    mk(0,0,1,1,1,1,1,1,1,4'h0,4'h0,4'h0,0),
    mk(0,0,0,1,1,1,1,1,0,4'h0,4'h0,4'h0,0),
    mk(1,0,0,1,1,1,1,1,0,4'h0,4'h0,4'h0,0),
    mk(1,0,0,1,1,1,1,1,1,4'h1,4'hA,4'h0,0),
    mk(1,0,0,1,1,1,1,1,1,4'h0,4'h5,4'h0,0),
    mk(1,0,0,1,1,1,1,1,0,4'h0,4'h5,4'h0,0),
    mk(1,0,0,1,1,1,1,1,0,4'h2,4'h5,4'h0,0),
    mk(1,0,0,1,1,1,1,1,0,4'h0,4'h5,4'h0,0),
    mk(1,0,0,1,1,1,1,1,1,4'h0,4'h5,4'h1,0),
    mk(1,0,0,1,1,1,1,1,1,4'h1,4'hA,4'h0,0),
    mk(1,0,0,1,1,1,1,1,0,4'h0,4'hA,4'h0,0),
    mk(1,0,0,1,1,1,1,1,0,4'h4,4'hA,4'h0,0),
    mk(1,0,0,1,1,1,1,1,0,4'h0,4'hA,4'h0,0),
    mk(1,0,0,1,1,1,1,1,1,4'h0,4'hA,4'h2,0),
    mk(1,1,0,1,1,1,1,1,1,4'h0,4'hA,4'h0,1)
  };

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    wdog++;
    if (wdog > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", wdog);
      summary();
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [21:0] v);
    setupDone = v[20]; patEnd = v[19]; tck = v[18]; tms = v[17]; tdi = v[16];
    trstN = v[15]; sysRstN = v[14]; auxRstN = v[13]; scanEn = v[12];
    scanClk = v[11:8]; scanIn = v[7:4]; soCmp = v[3:0];
  endtask

  task automatic step(input logic [21:0] v);
    @(negedge clk);
    apply(v);
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; clearErr = 1'b0;
    apply(22'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // Walk the reference table with row k replaced; expect m1 from row d1, m2 from row d2.
  task automatic runMut(input string tag, input int k, input logic [21:0] alt,
                        input logic [7:0] m1, input int d1, input logic [7:0] m2, input int d2);
    doReset();
    for (int i = 0; i < NROW; i++) begin
      logic [7:0] exp;
      step((i == k) ? alt : TAB[i]);
      exp = (i >= d2) ? m2 : ((i >= d1) ? m1 : 8'h00);
      check({tag, " flags per vector (R12)"}, 32'(errFlags), 32'(exp));
    end
    check({tag, " verdict valid R11"}, 32'(verdictValid), 32'(TAB[NROW-1][21]));
    check({tag, " verdict fail R11"}, 32'(verdictFail), 32'(m2 != 8'h00));
  endtask

  initial begin
    rstN = 1'b0; clearErr = 1'b0;
    apply(22'h0);
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset tck count", 32'(tckCount), 32'd0);
    check("R10 reset flags", 32'(errFlags), 32'd0);
    check("R11 reset verdict", 32'(verdictValid), 32'd0);

    // clean reference pattern
    runMut("clean", -1, 22'h0, 8'h00, 99, 8'h00, 99);
    check("R1 tck count", 32'(tckCount), 32'd4);
    check("R1 tms count", 32'(tmsCount), 32'd1);
    check("R1 tdi count", 32'(tdiCount), 32'd3);
    // R1: scan-phase TCK activity does not count
    for (int i = 0; i < 4; i++) step((TAB[16] & ~22'h080000) | (i[0] ? 22'h040000 : 22'h0));
    check("R1 frozen after setup", 32'(tckCount), 32'd4);

    // R2: TDI toggles not above TMS toggles
    runMut("R2", 1, TAB[1] & ~22'h010000, 8'h01, 5, 8'h01, 5);
    // R3: second low pulse on system reset
    runMut("R3", 3, TAB[3] & ~22'h004000, 8'h02, 5, 8'h02, 5);
    // R4: scan enable never pulses in setup
    runMut("R4", 3, TAB[3] & ~22'h001000, 8'h04, 5, 8'h04, 5);
    // R5: scan clock toggles in setup, then compare in setup
    runMut("R5 clk", 2, TAB[2] | 22'h000100, 8'h08, 2, 8'h08, 2);
    runMut("R5 cmp", 4, TAB[4] | 22'h000008, 8'h08, 4, 8'h08, 4);
    // R6: first capture window without clock pulse; R9 follows (only one capture)
    runMut("R6", 9, TAB[9] & ~22'h000F00, 8'h10, 11, 8'h90, 17);
    // R7: clock high when capture window opens
    runMut("R7", 8, TAB[8] | 22'h000100, 8'h20, 8, 8'h20, 8);
    // R9: no compare after second capture pulse
    runMut("R9", 16, TAB[16] & ~22'h00000F, 8'h80, 17, 8'h80, 17);
    // R8: compare during first load
    runMut("R8", 7, TAB[7] | 22'h000004, 8'h40, 7, 8'h40, 7);

    // R10: flags stay until clear
    for (int i = 0; i < 3; i++) step(TAB[17] & ~22'h080000);
    check("R10 sticky flags", 32'(errFlags), 32'h40);
    check("R10 sticky verdict", 32'(verdictFail), 32'd1);
    @(negedge clk); clearErr = 1'b1; apply(TAB[17] | 22'h000004);
    @(posedge clk); #1;
    check("R10 clear flags", 32'(errFlags), 32'd0);
    check("R10 clear verdict", 32'(verdictValid), 32'd0);
    @(negedge clk); clearErr = 1'b0;
    step(TAB[17] & ~22'h080000);
    check("R10 stays clear", 32'(errFlags), 32'd0);

    // R1: saturation of TCK count
    doReset();
    for (int i = 0; i < 65540; i++) step(i[0] ? 22'h0 : 22'h040000);
    check("R1 tck saturates", 32'(tckCount), 32'hFFFF);
    check("R1 tms unchanged", 32'(tmsCount), 32'd0);

    summary();
  end
endmodule